// File: doc/BRIEF.md
# Hybrid Significance Compression Encoder

This block sits on the write path of a cache data array. It looks at each 64-bit word on its way to the array and chooses between two storage formats that reduce bit-line activity.

The leading-run format measures how far the sign bit repeats downward from the top of the word. Runs of ones and runs of zeros are treated alike. The format stores a 6-bit run count in the top of the word together with only the low-order bits that carry information. The zero-byte format marks every all-zero byte with a flag and stores only the non-zero bytes.

The block compares the bit saving of the two formats and selects one for each word. It emits a 73-bit stored line and a 64-bit write-enable mask. The mask shows which data bit lines the array must drive. Words enter and leave through valid/ready handshakes, with one register stage between them.

Top module: `hybrid_sig_encoder`

## Requirements
- R1: In the zero-byte format, flag bit `out_line[64+k]` is 1 exactly when byte k of the word (bits 8k+7..8k) is all zero.
- R2: The run count is the number of bits directly below bit 63 that equal bit 63, counted downward and stopping at the first bit that differs, with a ceiling of 63. An all-zero or all-one word therefore has count 63.
- R3: The leading-run format (mode bit `out_line[72]` = 1) is chosen only when the count is at least 6 and (count - 6) is strictly greater than 8 times the number of zero bytes. Otherwise, including on a tie, the zero-byte format (`out_line[72]` = 0) is chosen.
- R4: In the leading-run format, `out_line[63:58]` holds the count, `out_line[63-count:0]` holds the same bits of the input word, and every other data position is 0.
- R5: In the leading-run format, the write-enable mask is 1 on bits 63..58 and on the low (64 - count) bits, and 0 elsewhere.
- R6: In the zero-byte format, `out_line[63:0]` equals the input word, and each mask byte is all ones for a non-zero byte and all zeros for a zero byte.
- R7: In the leading-run format, the flag bits `out_line[71:64]` are all 0.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_line` and `out_wmask` hold their values.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: A word accepted on a clock edge appears at the output, with `out_valid` = 1, after that same edge. Words leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Encoder can take a word |
| in_data | input | 64 | Word to be stored |
| out_valid | output | 1 | Encoded line available |
| out_ready | input | 1 | Consumer takes the line |
| out_line | output | 73 | Mode bit [72], zero-byte flags [71:64], data positions [63:0] |
| out_wmask | output | 64 | Per-bit-line write enable for data positions |

## Verification
Two things can happen in the same cycle: a new word is accepted, and the line already held in the register is handed off, because `out_ready` also opens `in_ready`. The bench drives `in_valid` and `out_ready` at random, so some cycles have both transfers together, some have a stall with a new word waiting, and some have an empty pipeline. Every word accepted is queued in the bench with its expected encoding. Each hand-off is then checked against the head of that queue, which catches any word that is lost, duplicated or overwritten during the overlap. Lines held during a stall are compared from one cycle to the next.

// File: rtl/hybrid_sig_encoder.sv
module hybrid_sig_encoder #(
  parameter int W = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W+8:0]  out_line,
  output logic [W-1:0]  out_wmask
);
  localparam int NB = W / 8;
  localparam int CW = $clog2(W);
  localparam int SW = CW + 1;

  logic [CW-1:0] cnt;
  logic [3:0]    nzero;
  logic [NB-1:0] zflag;
  logic          pick_run;
  logic [W+8:0]  enc_line;
  logic [W-1:0]  enc_mask;

  always_comb begin
    cnt = CW'(W - 1);
    for (int i = 0; i < W - 1; i++)
      if (in_data[i] ^ in_data[W-1]) cnt = CW'(W - 2 - i);
  end

  always_comb begin
    nzero = '0;
    for (int k = 0; k < NB; k++) begin
      zflag[k] = (in_data[8*k +: 8] == 8'h00);
      nzero = nzero + 4'(zflag[k]);
    end
  end

  assign pick_run = (cnt >= CW'(6)) &&
                    (({1'b0, cnt} - SW'(6)) > SW'({nzero, 3'b000}));

  always_comb begin
    enc_line = '0;
    enc_mask = '0;
    if (pick_run) begin
      enc_line[W+8] = 1'b1;
      for (int i = 0; i < W; i++) begin
        if (i >= W - CW) begin
          enc_mask[i] = 1'b1;
          enc_line[i] = cnt[i-(W-CW)];
        end else if (i < W - int'(cnt)) begin
          enc_mask[i] = 1'b1;
          enc_line[i] = in_data[i];
        end
      end
    end else begin
      enc_line[W-1:0] = in_data;
      enc_line[W+7:W] = zflag;
      for (int k = 0; k < NB; k++)
        enc_mask[8*k +: 8] = {8{~zflag[k]}};
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_line  <= '0;
      out_wmask <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_line  <= enc_line;
        out_wmask <= enc_mask;
      end
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_line) && $stable(out_wmask));
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  a_r7_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_line[W+8] |-> out_line[W+7:W] == '0);
  a_r3_min_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_line[W+8] |-> out_line[W-1:W-CW] >= CW'(6));
  a_r5_count_lines: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_line[W+8] |-> &out_wmask[W-1:W-CW]);
  a_r6_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_line[W-1:0] & ~out_wmask) == '0);
endmodule

// File: tb/hybrid_sig_encoder_bench.sv
module hybrid_sig_encoder_bench;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, out_ready = 0;
  logic [63:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [72:0] out_line;
  logic [63:0] out_wmask;

  int errors = 0, checks = 0;
  logic [72:0]  q_line[$];
  logic [63:0]  q_mask[$];
  logic [63:0]  q_word[$];

  always #2.5 clk = ~clk;

  hybrid_sig_encoder u_hybrid_sig_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_line(out_line), .out_wmask(out_wmask));

  function automatic int ref_count(logic [63:0] d);
    int n = 0;
    for (int i = 62; i >= 0; i--) begin
      if (d[i] != d[63]) break;
      n++;
    end
    return n;
  endfunction

  function automatic int ref_zeros(logic [63:0] d);
    int n = 0;
    for (int k = 0; k < 8; k++) if (d[8*k +: 8] == 8'h00) n++;
    return n;
  endfunction

  function automatic logic [72:0] ref_line(logic [63:0] d);
    int c = ref_count(d);
    int z = ref_zeros(d);
    logic [72:0] l = '0;
    if (c >= 6 && (c - 6) > 8 * z) begin
      l[72] = 1'b1;
      l[63:58] = 6'(c);
      for (int i = 0; i < 64 - c; i++) l[i] = d[i];
    end else begin
      l[63:0] = d;
      for (int k = 0; k < 8; k++) l[64+k] = (d[8*k +: 8] == 8'h00);
    end
    return l;
  endfunction

  function automatic logic [63:0] ref_mask(logic [63:0] d);
    int c = ref_count(d);
    int z = ref_zeros(d);
    logic [63:0] m = '0;
    if (c >= 6 && (c - 6) > 8 * z) begin
      m[63:58] = '1;
      for (int i = 0; i < 64 - c; i++) m[i] = 1'b1;
    end else begin
      for (int k = 0; k < 8; k++) m[8*k +: 8] = (d[8*k +: 8] == 8'h00) ? 8'h00 : 8'hFF;
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [72:0] act, input logic [72:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(input logic [63:0] w, input logic [72:0] el, input logic [63:0] em);
    check(out_line[72] == el[72], "R3 mode", 73'(out_line[72]), 73'(el[72]));
    if (el[72]) begin
      check(out_line[63:58] == el[63:58], "R2 count", 73'(out_line[63:58]), 73'(el[63:58]));
      check(out_line[63:0] == el[63:0], "R4 run data", 73'(out_line[63:0]), 73'(el[63:0]));
      check(out_wmask == em, "R5 run mask", 73'(out_wmask), 73'(em));
      check(out_line[71:64] == 8'h00, "R7 flags", 73'(out_line[71:64]), 73'(0));
    end else begin
      check(out_line[71:64] == el[71:64], "R1 flags", 73'(out_line[71:64]), 73'(el[71:64]));
      check(out_line[63:0] == w && out_wmask == em, "R6 byte data/mask",
            {9'h0, out_wmask}, {9'h0, em});
    end
  endtask

  logic [63:0] corner[10] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001,
    64'hFFFF_FFFF_FFFF_FF80, 64'h0000_0000_0000_0100, 64'h03FF_FFFF_FFFF_FFFF,
    64'h0300_0000_0000_0000, 64'h0100_0000_0000_0000, 64'hFFFF_FFF0_1234_5678,
    64'h8000_0000_0000_0000 };

  initial begin
    bit acc_prev = 0;
    bit hold_prev = 0;
    logic [72:0] hl;
    logic [63:0] hm;
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 reset", 73'({out_valid, in_ready}), 73'(1));
    rst_n = 1;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (acc_prev)
        check(out_valid == 1'b1, "R10 latency", 73'(out_valid), 73'(1));
      if (hold_prev)
        check(out_valid && out_line == hl && out_wmask == hm, "R8 hold", out_line, hl);
      if (cyc < 10) begin
        in_valid = 1;
        in_data = corner[cyc];
        out_ready = 1;
      end else begin
        in_valid = ($urandom % 4) != 0;
        case ($urandom % 4)
          0: in_data = {$urandom, $urandom};
          1: in_data = 64'($signed({$urandom} >> ($urandom % 32)));
          2: in_data = -64'($urandom % 300);
          default: in_data = {$urandom, $urandom} & {8{($urandom % 2) ? 8'hFF : 8'h00}} >> (8 * ($urandom % 8));
        endcase
        out_ready = ($urandom % 3) != 0;
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R8 ready", 73'(in_ready), 73'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q_line.size() == 0) check(0, "R10 order", out_line, 73'(0));
        else check_out(q_word.pop_front(), q_line.pop_front(), q_mask.pop_front());
      end
      hold_prev = out_valid && !out_ready;
      hl = out_line;
      hm = out_wmask;
      acc_prev = in_valid && in_ready;
      if (acc_prev) begin
        q_word.push_back(in_data);
        q_line.push_back(ref_line(in_data));
        q_mask.push_back(ref_mask(in_data));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule